// File: doc/BRIEF.md
# Shared-Timer Watchdog

This block is a watchdog that owns no counter of its own. It shares a free-running 16-bit timer, which is split into separately writable low and high bytes, and one compare channel that has an offset byte and a compare byte. Software reaches every control through a byte-wide register port with a 3-bit address. Timer counts are gated by a tick-enable input that stands in for the selected clock source. The 3-bit source select is exported on `clk_sel_o` for the clock logic outside the block.

Setting the watchdog enable bit forces the timer to run and locks several neighbouring controls against writes. Software services the watchdog by writing any value to the compare byte. That write re-arms the compare point at the current high byte plus the offset. If the high byte reaches the compare byte at a low-byte rollover, the block emits a one-cycle reset pulse, and the same pulse returns its own registers to their reset values.

Register map (address: content): 0 mode (bit 7 watchdog enable, bit 6 idle-stop, bits 2:0 source select, other bits read 0); 1 control (bit 0 run); 2 timer low byte; 3 timer high byte; 4 channel mode; 5 offset; 6 compare. Register reads are combinational from `addr_i`.

Top module: `cnt_wdt`

## Requirements
- R1: After reset, the mode register reads 0x80, control reads 0x00, both timer bytes read 0x00, offset reads 0xFF, compare reads 0x00, channel mode reads 0x48 and `wd_rst_o` is 0.
- R2: While the enable bit (mode bit 7) is set, the timer advances by one on every clock with `tick_i` high, whatever the run bit holds. The control register reads back the run bit as it was last written, so it reads 0 when software never set it.
- R3: While enabled, writes to address 2 or 3 leave the timer unchanged.
- R4: While enabled, a write to the mode register changes only bit 7. Idle-stop and source select keep their values, and so does `clk_sel_o`.
- R5: While enabled, the channel mode address reads 0x48 (software-timer mode) and writes to it are dropped. After the enable bit is cleared, it reads the stored value again.
- R6: While enabled, a write of any data to address 6 loads the compare byte with (timer high byte + offset) mod 256. While disabled, such a write stores the written data.
- R7: While enabled, when the low byte rolls from 0xFF to 0x00 and the new high byte equals the compare byte, `wd_rst_o` is high for exactly the one cycle that follows that clock edge. Equality at any other time does not cause a reset.
- R8: The reset pulse returns every register to its R1 value, including clearing the timer.
- R9: While disabled, the timer counts only with the run bit set. With idle-stop (bit 6) set and `idle_i` high it pauses. Timer bytes are writable.
- R10: While disabled, a high-byte match at a rollover gives no reset pulse.
- R11: Clearing the enable bit releases every lock at once. While enabled, `idle_i` has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable from the selected timer clock |
| idle_i | input | 1 | Core idle indication |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| clk_sel_o | output | 3 | Selected timer clock source |
| wd_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The rollover comparison is tested in three situations. In the first, the timer starts part-way through a high byte that is already equal to the compare byte, and no reset is expected because equality alone is not the trigger. In the second, a serviced compare point lies two rollovers ahead, and the bench checks the exact cycle of the pulse; this separates matching on the new high byte from matching on the old one. In the third, the same crossing happens with the watchdog disabled, and no reset is expected. The service write is tried with an offset that wraps past 0xFF and with a plain offset, which tells a modulo adder apart from a direct store. Lock tests write each guarded register while enabled and again after disabling, so that a lock that is stuck on and a lock that is missing each show up.

// File: rtl/cnt_wdt_pkg.sv
package cnt_wdt_pkg;
  typedef enum logic [2:0] {
    A_MODE    = 3'd0,
    A_CTRL    = 3'd1,
    A_CNT_LO  = 3'd2,
    A_CNT_HI  = 3'd3,
    A_CH_MODE = 3'd4,
    A_OFFSET  = 3'd5,
    A_CMP     = 3'd6
  } reg_addr_e;

  localparam int unsigned MODE_EN_BIT   = 7;
  localparam int unsigned MODE_IDLE_BIT = 6;
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam logic [7:0]  SW_TIMER_CODE = 8'h48;
  localparam logic [7:0]  OFFSET_RST    = 8'hFF;
endpackage

// File: rtl/cnt_wdt_regs.sv
module cnt_wdt_regs
  import cnt_wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wd_en_o,
  output logic              idle_stop_o,
  output logic [SEL_W-1:0]  clk_sel_o,
  output logic              run_o,
  output logic [DATA_W-1:0] ch_mode_o,
  output logic [DATA_W-1:0] offset_o,
  output logic              cnt_lo_we_o,
  output logic              cnt_hi_we_o,
  output logic              cmp_we_o,
  output logic              svc_o
);
  logic              wd_en_q, idle_q, run_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] ch_mode_q, offset_q;
  logic              lock;
  logic              wr_mode, wr_ctrl, wr_ch, wr_off, wr_cmp;

  assign lock    = wd_en_q;
  assign wr_mode = wr_i && (addr_i == A_MODE);
  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_ch   = wr_i && (addr_i == A_CH_MODE);
  assign wr_off  = wr_i && (addr_i == A_OFFSET);
  assign wr_cmp  = wr_i && (addr_i == A_CMP);

  assign cnt_lo_we_o = wr_i && (addr_i == A_CNT_LO) && !lock;
  assign cnt_hi_we_o = wr_i && (addr_i == A_CNT_HI) && !lock;
  assign cmp_we_o    = wr_cmp && !lock;
  assign svc_o       = wr_cmp && lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_en_q   <= 1'b1;
      idle_q    <= 1'b0;
      sel_q     <= '0;
      run_q     <= 1'b0;
      ch_mode_q <= '0;
      offset_q  <= OFFSET_RST;
    end else if (clr_i) begin
      wd_en_q   <= 1'b1;
      idle_q    <= 1'b0;
      sel_q     <= '0;
      run_q     <= 1'b0;
      ch_mode_q <= '0;
      offset_q  <= OFFSET_RST;
    end else begin
      if (wr_mode) begin
        wd_en_q <= wdata_i[MODE_EN_BIT];
        if (!lock) begin
          idle_q <= wdata_i[MODE_IDLE_BIT];
          sel_q  <= wdata_i[SEL_W-1:0];
        end
      end
      if (wr_ctrl)         run_q     <= wdata_i[CTRL_RUN_BIT];
      if (wr_ch && !lock)  ch_mode_q <= wdata_i;
      if (wr_off)          offset_q  <= wdata_i;
    end
  end

  assign wd_en_o     = wd_en_q;
  assign idle_stop_o = idle_q;
  assign clk_sel_o   = sel_q;
  assign run_o       = run_q;
  assign ch_mode_o   = lock ? SW_TIMER_CODE : ch_mode_q;
  assign offset_o    = offset_q;

  // R4
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en_q && !clr_i) |=> ($stable(sel_q) && $stable(idle_q)));

  // R5
  ch_mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en_q && !clr_i) |=> $stable(ch_mode_q));
endmodule

// File: rtl/cnt_wdt_timer.sv
module cnt_wdt_timer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              idle_i,
  input  logic              wd_en_i,
  input  logic              run_i,
  input  logic              idle_stop_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_lo_o,
  output logic [DATA_W-1:0] cnt_hi_o,
  output logic [DATA_W-1:0] hi_next_o,
  output logic              ovf_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] lo_q, hi_q;
  logic              running, paused, step;

  assign running = wd_en_i || run_i;
  // idle-stop only honoured with the watchdog off
  assign paused  = !wd_en_i && idle_stop_i && idle_i;
  assign step    = tick_i && running && !paused && !lo_we_i && !hi_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we_i) lo_q <= wdata_i;
      if (hi_we_i) hi_q <= wdata_i;
      if (step) begin
        lo_q <= lo_q + 1'b1;
        if (&lo_q) hi_q <= hi_q + 1'b1;
      end
    end
  end

  assign cnt_lo_o  = lo_q;
  assign cnt_hi_o  = hi_q;
  assign hi_next_o = hi_q + 1'b1;
  assign ovf_o     = step && (&lo_q);

  // R2
  forced_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en_i && tick_i && !clr_i) |=>
      ({hi_q, lo_q} == CNT_W'($past({hi_q, lo_q}) + 1'b1)));
endmodule

// File: rtl/cnt_wdt_cmp.sv
module cnt_wdt_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wd_en_i,
  input  logic              ovf_i,
  input  logic [DATA_W-1:0] hi_next_i,
  input  logic [DATA_W-1:0] cnt_hi_i,
  input  logic [DATA_W-1:0] offset_i,
  input  logic              svc_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              match_o,
  output logic              wd_rst_o
);
  logic [DATA_W-1:0] cmp_q, reload;
  logic              rst_q;

  assign reload  = cnt_hi_i + offset_i;
  assign match_o = wd_en_i && ovf_i && (hi_next_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= match_o;
      if (match_o)       cmp_q <= '0;
      else if (svc_i)    cmp_q <= reload;
      else if (cmp_we_i) cmp_q <= wdata_i;
    end
  end

  assign cmp_o    = cmp_q;
  assign wd_rst_o = rst_q;

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |=> !wd_rst_o);

  // R6
  service_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !match_o) |=> (cmp_q == DATA_W'($past(cnt_hi_i) + $past(offset_i))));

  // R10
  no_rst_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> !wd_rst_o);
endmodule

// File: rtl/cnt_wdt.sv
module cnt_wdt
  import cnt_wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              idle_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  clk_sel_o,
  output logic              wd_rst_o
);
  localparam int unsigned PAD_W = DATA_W - 2 - SEL_W;

  logic              wd_en, idle_stop, run;
  logic [DATA_W-1:0] ch_mode, offset, cnt_lo, cnt_hi, hi_next, cmp;
  logic              lo_we, hi_we, cmp_we, svc, ovf, match;

  cnt_wdt_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(match),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .wd_en_o(wd_en), .idle_stop_o(idle_stop), .clk_sel_o(clk_sel_o),
    .run_o(run), .ch_mode_o(ch_mode), .offset_o(offset),
    .cnt_lo_we_o(lo_we), .cnt_hi_we_o(hi_we),
    .cmp_we_o(cmp_we), .svc_o(svc)
  );

  cnt_wdt_timer #(.DATA_W(DATA_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(match),
    .tick_i(tick_i), .idle_i(idle_i),
    .wd_en_i(wd_en), .run_i(run), .idle_stop_i(idle_stop),
    .lo_we_i(lo_we), .hi_we_i(hi_we), .wdata_i(wdata_i),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .hi_next_o(hi_next), .ovf_o(ovf)
  );

  cnt_wdt_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wd_en_i(wd_en),
    .ovf_i(ovf), .hi_next_i(hi_next), .cnt_hi_i(cnt_hi), .offset_i(offset),
    .svc_i(svc), .cmp_we_i(cmp_we), .wdata_i(wdata_i),
    .cmp_o(cmp), .match_o(match), .wd_rst_o(wd_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE:    rdata_o = {wd_en, idle_stop, {PAD_W{1'b0}}, clk_sel_o};
      A_CTRL:    rdata_o = {{(DATA_W-1){1'b0}}, run};
      A_CNT_LO:  rdata_o = cnt_lo;
      A_CNT_HI:  rdata_o = cnt_hi;
      A_CH_MODE: rdata_o = ch_mode;
      A_OFFSET:  rdata_o = offset;
      A_CMP:     rdata_o = cmp;
      default:   rdata_o = '0;
    endcase
  end

  // R3
  cnt_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en && !tick_i && !match) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: tb/cnt_wdt_test.sv
module cnt_wdt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, idle = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] clk_sel;
  logic       wd_rst;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cnt_wdt uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .idle_i(idle),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .clk_sel_o(clk_sel), .wd_rst_o(wd_rst)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rreg(0, d); check("R1 mode", d, 8'h80);
    rreg(1, d); check("R1 ctrl", d, 8'h00);
    rreg(2, d); check("R1 cnt_lo", d, 8'h00);
    rreg(3, d); check("R1 cnt_hi", d, 8'h00);
    rreg(4, d); check("R1 ch_mode", d, 8'h48);
    rreg(5, d); check("R1 offset", d, 8'hFF);
    rreg(6, d); check("R1 cmp", d, 8'h00);
    check("R1 wd_rst", wd_rst, 0);
  endtask

  task automatic t_forced_run;
    logic [7:0] d;
    ticks(5);
    rreg(2, d); check("R2 count without run", d, 5);
    rreg(1, d); check("R2 run reads 0", d, 0);
    wreg(1, 8'h00); ticks(3);
    rreg(2, d); check("R2 run=0 write ignored", d, 8);
    wreg(2, 8'h55); wreg(3, 8'h66);
    rreg(2, d); check("R3 lo write locked", d, 8);
    rreg(3, d); check("R3 hi write locked", d, 0);
  endtask

  task automatic t_locks;
    logic [7:0] d;
    wreg(0, 8'hC5);
    rreg(0, d); check("R4 mode fields frozen", d, 8'h80);
    check("R4 clk_sel frozen", clk_sel, 0);
    wreg(4, 8'h11);
    rreg(4, d); check("R5 ch_mode forced", d, 8'h48);
    wreg(0, 8'h00);
    rreg(4, d); check("R5 ch_mode stored after disable", d, 8'h00);
    wreg(4, 8'h11);
    rreg(4, d); check("R11 ch_mode writable", d, 8'h11);
    wreg(0, 8'h45);
    rreg(0, d); check("R11 mode writable", d, 8'h45);
    check("R11 clk_sel", clk_sel, 5);
  endtask

  task automatic t_disabled_count;
    logic [7:0] d;
    wreg(0, 8'h00); wreg(1, 8'h00);
    wreg(2, 8'h20); wreg(3, 8'h01);
    ticks(4);
    rreg(2, d); check("R9 stopped without run", d, 8'h20);
    rreg(3, d); check("R9 hi written", d, 8'h01);
    wreg(1, 8'h01); ticks(4);
    rreg(2, d); check("R9 runs with run", d, 8'h24);
    wreg(0, 8'h40); idle = 1'b1; ticks(3);
    rreg(2, d); check("R9 idle pause", d, 8'h24);
    idle = 1'b0; ticks(2);
    rreg(2, d); check("R9 resumes", d, 8'h26);
    wreg(0, 8'hC0); wreg(1, 8'h00); idle = 1'b1; ticks(3);
    rreg(2, d); check("R11 idle ignored when enabled", d, 8'h29);
    idle = 1'b0;
  endtask

  task automatic t_disabled_match;
    logic [7:0] d;
    bit seen = 1'b0;
    wreg(0, 8'h00); wreg(1, 8'h01);
    wreg(2, 8'hFE); wreg(3, 8'h02); wreg(6, 8'h03);
    rreg(6, d); check("R6 direct store when disabled", d, 8'h03);
    @(negedge clk); tick = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); if (wd_rst) seen = 1'b1;
    end
    tick = 1'b0;
    check("R10 no reset when disabled", seen, 0);
    rreg(3, d); check("R10 crossed into match", d, 8'h03);
    wreg(1, 8'h00);
  endtask

  task automatic t_wrap_service;
    logic [7:0] d;
    wreg(0, 8'h00); wreg(3, 8'hF0); wreg(0, 8'h80);
    wreg(5, 8'h20); wreg(6, 8'hAA);
    rreg(6, d); check("R6 service wraps", d, 8'h10);
  endtask

  task automatic t_expire;
    logic [7:0] d;
    int first = 0;
    bit seen_late = 1'b0;
    wreg(0, 8'h00); wreg(2, 8'hF0); wreg(3, 8'h05); wreg(6, 8'h05);
    wreg(0, 8'h80); wreg(5, 8'h02); wreg(6, 8'h00);
    rreg(6, d); check("R6 service load", d, 8'h07);
    @(negedge clk); tick = 1'b1;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (wd_rst) begin first = i; tick = 1'b0; break; end
    end
    tick = 1'b0;
    check("R7 pulse cycle", first, 272);
    @(negedge clk); check("R7 pulse one cycle", wd_rst, 0);
    rreg(0, d); check("R8 mode reset", d, 8'h80);
    rreg(5, d); check("R8 offset reset", d, 8'hFF);
    rreg(6, d); check("R8 cmp reset", d, 8'h00);
    rreg(2, d); check("R8 cnt_lo reset", d, 8'h00);
    rreg(3, d); check("R8 cnt_hi reset", d, 8'h00);
    @(negedge clk); if (wd_rst) seen_late = 1'b1;
    check("R7 no further pulse", seen_late, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forced_run();
    t_locks();
    t_disabled_count();
    t_disabled_match();
    t_wrap_service();
    t_expire();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule